// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation that the TLB could not supply by reading a two-level page table from memory. A requester hands over a 32-bit linear address together with the physical base of the top-level directory. The walker splits the linear address into a directory index, a table index and a byte offset. It reads the directory entry, and if that entry is present it reads the page-table entry it points to. It then returns the physical frame and the complete physical address, or a fault that names the level whose entry was not present.

Each level costs one dependent memory read, and the second address cannot be formed until the first read returns. The walker is therefore a small sequencer. It keeps one read outstanding on a plain read port whose response latency is not fixed. While it works it holds busy high and refuses new requests. The walk ends with a one-cycle `done` pulse or a one-cycle `fault` pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1 and `busy`, `done`, `fault` and `mem_rd_en` are all 0.
- R2: The first read of a walk is at byte address {req_root[31:12], 12'h000} + 4*req_vaddr[31:22]. Bits 11:0 of `req_root` have no effect.
- R3: The second read is at byte address {dir_entry[31:12], 12'h000} + 4*req_vaddr[21:12], where dir_entry is the data returned by the first read.
- R4: When both entries have bit 0 set (present), `done` pulses. In that cycle `resp_frame` = pte[31:12] and `resp_paddr` = {pte[31:12], req_vaddr[11:0]}. Entry bits 11:1 do not affect the result.
- R5: A directory entry with bit 0 clear ends the walk with `fault`=1 and `fault_level`=0, and no second read is issued.
- R6: A page-table entry with bit 0 clear ends the walk with `fault`=1 and `fault_level`=1, after exactly two reads.
- R7: From the cycle after a request is accepted up to and including the cycle of the `done` or `fault` pulse, `busy`=1 and `req_ready`=0. Requests and address changes during that time do not affect the walk.
- R8: `mem_rd_en` is a one-cycle pulse. No new read is issued until the previous read has returned `mem_rd_valid`.
- R9: `done` and `fault` are never high together and each lasts exactly one cycle. The walker is ready again in the following cycle.
- R10: Asserting reset in the middle of a walk returns the walker to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; a request is accepted when both are high |
| req_vaddr | input | 32 | Linear address to translate |
| req_root | input | 32 | Physical base of the directory (low 12 bits ignored) |
| mem_rd_en | output | 1 | Memory read issue pulse |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Entry returned by memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Not-present pulse |
| fault_level | output | 1 | 0 = directory entry missing, 1 = table entry missing |
| resp_frame | output | 20 | Resolved physical frame number |
| resp_paddr | output | 32 | Resolved physical address |

## Verification
The hardest case to reach is a walk that is corrupted while it is running. This covers a held request and a changing address during the busy window, a directory fault that must suppress the second read, and a reset that lands while a read is outstanding. The behavioural memory in the bench serves each read after a latency set per vector, from one to four cycles. Some vectors keep `req_valid` high with an inverted address and root for the whole walk. A directed test drops reset right after the first read is issued.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_ISSUE_DIR,
      WS_WAIT_DIR,
      WS_ISSUE_TBL,
      WS_WAIT_TBL,
      WS_FINISH,
      WS_ABORT
   } walk_state_e;

   localparam logic LEVEL_DIR = 1'b0;
   localparam logic LEVEL_TBL = 1'b1;
endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
   parameter int ADDR_W = 32,
   parameter int DIR_W  = 10,
   parameter int TBL_W  = 10,
   localparam int OFF_W = ADDR_W - DIR_W - TBL_W
) (
   input  logic [ADDR_W-1:0] vaddr,
   output logic [DIR_W-1:0]  dir_idx,
   output logic [TBL_W-1:0]  tbl_idx,
   output logic [OFF_W-1:0]  offset
);
   assign dir_idx = vaddr[ADDR_W-1 -: DIR_W];
   assign tbl_idx = vaddr[OFF_W +: TBL_W];
   assign offset  = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4,
   localparam int FRAME_W    = ADDR_W - OFF_W,
   localparam int SHIFT      = $clog2(ENTRY_BYTES)
) (
   input  logic [FRAME_W-1:0] base_frame,
   input  logic [IDX_W-1:0]   idx,
   output logic [ADDR_W-1:0]  entry_addr
);
   logic [ADDR_W-1:0] base_byte;
   logic [ADDR_W-1:0] idx_ext;

   assign base_byte = {base_frame, {OFF_W{1'b0}}};
   assign idx_ext   = ADDR_W'(idx);

   generate
      if (SHIFT == 0) begin : g_byte_entries
         assign entry_addr = base_byte + idx_ext;
      end else begin : g_wide_entries
         assign entry_addr = base_byte + (idx_ext << SHIFT);
      end
   endgenerate
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int   ENTRY_W     = 32,
   parameter int   FRAME_W     = 20,
   parameter int   PRESENT_BIT = 0,
   parameter bit   PRESENT_HI  = 1'b1
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               present,
   output logic [FRAME_W-1:0] frame
);
   logic unused_flag_bits;

   assign frame            = entry[ENTRY_W-1 -: FRAME_W];
   assign unused_flag_bits = ^entry;

   generate
      if (PRESENT_HI) begin : g_pres_high
         assign present = entry[PRESENT_BIT];
      end else begin : g_pres_low
         assign present = ~entry[PRESENT_BIT];
      end
   endgenerate
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_valid,
   input  logic        present,
   output walk_state_e state,
   output logic        busy,
   output logic        rd_en,
   output logic        sel_dir,
   output logic        cap_dir,
   output logic        cap_tbl,
   output logic        done,
   output logic        fault,
   output logic        fault_level
);
   walk_state_e nxt;
   logic        level_q;

   always_comb begin
      nxt = state;
      unique case (state)
         WS_IDLE:      if (start) nxt = WS_ISSUE_DIR;
         WS_ISSUE_DIR: nxt = WS_WAIT_DIR;
         WS_WAIT_DIR:  if (rd_valid) nxt = present ? WS_ISSUE_TBL : WS_ABORT;
         WS_ISSUE_TBL: nxt = WS_WAIT_TBL;
         WS_WAIT_TBL:  if (rd_valid) nxt = present ? WS_FINISH : WS_ABORT;
         WS_FINISH:    nxt = WS_IDLE;
         WS_ABORT:     nxt = WS_IDLE;
         default:      nxt = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= WS_IDLE;
         level_q <= LEVEL_DIR;
      end else begin
         state <= nxt;
         if (state == WS_WAIT_DIR && rd_valid) level_q <= LEVEL_DIR;
         if (state == WS_WAIT_TBL && rd_valid) level_q <= LEVEL_TBL;
      end
   end

   assign busy        = (state != WS_IDLE);
   assign rd_en       = (state == WS_ISSUE_DIR) || (state == WS_ISSUE_TBL);
   assign sel_dir     = (state == WS_ISSUE_DIR);
   assign cap_dir     = (state == WS_WAIT_DIR) && rd_valid && present;
   assign cap_tbl     = (state == WS_WAIT_TBL) && rd_valid && present;
   assign done        = (state == WS_FINISH);
   assign fault       = (state == WS_ABORT);
   assign fault_level = level_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int ENTRY_W     = 32,
   parameter int PRESENT_BIT = 0,
   parameter bit PRESENT_HI  = 1'b1,
   localparam int OFF_W       = ADDR_W - DIR_W - TBL_W,
   localparam int FRAME_W     = ADDR_W - OFF_W,
   localparam int ENTRY_BYTES = ENTRY_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_vaddr,
   input  logic [ADDR_W-1:0]  req_root,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic               mem_rd_valid,
   input  logic [ENTRY_W-1:0] mem_rd_data,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic               fault_level,
   output logic [FRAME_W-1:0] resp_frame,
   output logic [ADDR_W-1:0]  resp_paddr
);
   generate
      if (OFF_W < 1) begin : g_bad_split
         $error("ptw_walker: index fields leave no offset bits");
      end
      if (ENTRY_W % 8 != 0) begin : g_bad_entry
         $error("ptw_walker: entry width must be whole bytes");
      end
      if (ENTRY_W < FRAME_W + 1) begin : g_bad_frame
         $error("ptw_walker: entry too narrow for frame and present flag");
      end
      if (PRESENT_BIT >= ENTRY_W - FRAME_W) begin : g_bad_pres
         $error("ptw_walker: present flag overlaps the frame field");
      end
   endgenerate

   walk_state_e          state;
   logic                 start;
   logic                 present;
   logic                 sel_dir;
   logic                 cap_dir;
   logic                 cap_tbl;
   logic [FRAME_W-1:0]   entry_frame;
   logic [ADDR_W-1:0]    vaddr_q;
   logic [FRAME_W-1:0]   root_frame_q;
   logic [FRAME_W-1:0]   tbl_frame_q;
   logic [FRAME_W-1:0]   phys_frame_q;
   logic [DIR_W-1:0]     dir_idx;
   logic [TBL_W-1:0]     tbl_idx;
   logic [OFF_W-1:0]     offset;
   logic [ADDR_W-1:0]    dir_entry_addr;
   logic [ADDR_W-1:0]    tbl_entry_addr;
   logic                 unused_root_low;

   assign req_ready       = (state == WS_IDLE);
   assign start           = req_valid && req_ready;
   assign unused_root_low = ^req_root[OFF_W-1:0];

   ptw_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .rd_valid    (mem_rd_valid),
      .present     (present),
      .state       (state),
      .busy        (busy),
      .rd_en       (mem_rd_en),
      .sel_dir     (sel_dir),
      .cap_dir     (cap_dir),
      .cap_tbl     (cap_tbl),
      .done        (done),
      .fault       (fault),
      .fault_level (fault_level)
   );

   ptw_addr_split #(.ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W)) u_split (
      .vaddr   (vaddr_q),
      .dir_idx (dir_idx),
      .tbl_idx (tbl_idx),
      .offset  (offset)
   );

   ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(DIR_W),
                    .ENTRY_BYTES(ENTRY_BYTES)) u_dir_addr (
      .base_frame (root_frame_q),
      .idx        (dir_idx),
      .entry_addr (dir_entry_addr)
   );

   ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(TBL_W),
                    .ENTRY_BYTES(ENTRY_BYTES)) u_tbl_addr (
      .base_frame (tbl_frame_q),
      .idx        (tbl_idx),
      .entry_addr (tbl_entry_addr)
   );

   ptw_entry_decode #(.ENTRY_W(ENTRY_W), .FRAME_W(FRAME_W),
                      .PRESENT_BIT(PRESENT_BIT), .PRESENT_HI(PRESENT_HI)) u_dec (
      .entry   (mem_rd_data),
      .present (present),
      .frame   (entry_frame)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vaddr_q      <= '0;
         root_frame_q <= '0;
         tbl_frame_q  <= '0;
         phys_frame_q <= '0;
      end else begin
         if (start) begin
            vaddr_q      <= req_vaddr;
            root_frame_q <= req_root[ADDR_W-1:OFF_W];
         end
         if (cap_dir) tbl_frame_q  <= entry_frame;
         if (cap_tbl) phys_frame_q <= entry_frame;
      end
   end

   assign mem_rd_addr = sel_dir ? dir_entry_addr : tbl_entry_addr;
   assign resp_frame  = phys_frame_q;
   assign resp_paddr  = {phys_frame_q, offset};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic mem_rd_en,
   input logic mem_rd_valid,
   input logic busy,
   input logic done,
   input logic fault,
   input logic fault_level
);
   logic       pending;
   logic [1:0] reads;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         reads   <= 2'd0;
      end else begin
         if (mem_rd_en)         pending <= 1'b1;
         else if (mem_rd_valid) pending <= 1'b0;
         if (req_valid && req_ready) reads <= 2'd0;
         else if (mem_rd_en && reads != 2'd3) reads <= reads + 2'd1;
      end
   end

   // R8
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !pending);

   // R8
   read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R7
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R7
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   // R9
   exclusive_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> (!done && !fault && req_ready));

   // R4
   done_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (reads == 2'd2));

   // R5
   dir_fault_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !fault_level) |-> (reads == 2'd1));

   // R6
   tbl_fault_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && fault_level) |-> (reads == 2'd2));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .mem_rd_en    (mem_rd_en),
   .mem_rd_valid (mem_rd_valid),
   .busy         (busy),
   .done         (done),
   .fault        (fault),
   .fault_level  (fault_level)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [31:0] va;
      logic [31:0] root;
      logic [31:0] pde;
      logic [31:0] pte;
      logic [2:0]  lat;
      logic        noise;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_3123, 32'h0010_0000, 32'h0020_0001, 32'h0ABC_D001, 3'd1, 1'b0},
      '{32'hFFFF_FFFF, 32'h0030_0FFF, 32'h1234_5007, 32'hFFFF_F003, 3'd2, 1'b1},
      '{32'h0000_0000, 32'h0000_0000, 32'h0050_0000, 32'h0000_0001, 3'd3, 1'b0},
      '{32'h8020_1ABC, 32'h7000_0000, 32'h0060_1001, 32'h0077_7FFE, 3'd4, 1'b0},
      '{32'h1234_5678, 32'h0000_1000, 32'hFFFF_F001, 32'h0000_1001, 3'd1, 1'b1},
      '{32'h003F_F000, 32'h0040_0000, 32'h0000_0FFE, 32'h0000_0001, 3'd2, 1'b1},
      '{32'hC000_0FFF, 32'hFFFF_F000, 32'h0000_0001, 32'h8000_0001, 3'd3, 1'b0},
      '{32'h0001_F00F, 32'h0200_0000, 32'h0300_0FFF, 32'h0400_0FFE, 3'd1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_root = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        busy, done, fault, fault_level;
   logic [19:0] resp_frame;
   logic [31:0] resp_paddr;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   ptw_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_root(req_root), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .fault(fault),
      .fault_level(fault_level), .resp_frame(resp_frame), .resp_paddr(resp_paddr)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(req_ready == 1'b1, {req, " ready"}, 32'(req_ready), 32'd1);
      check({busy, done, fault, mem_rd_en} == 4'b0000, {req, " idle outputs"},
            32'({busy, done, fault, mem_rd_en}), 32'd0);
   endtask

   task automatic walk(input vec_t v, input string tag);
      logic [31:0] exp_dir;
      logic [31:0] exp_tbl;
      logic [31:0] resp;
      int reads = 0;
      int cd = -1;
      int cyc = 0;
      bit fin = 0;
      exp_dir = {v.root[31:12], 12'h000} + {20'h0, v.va[31:22], 2'b00};
      exp_tbl = {v.pde[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
      resp = '0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = v.va; req_root = v.root;
      @(negedge clk);
      req_valid = v.noise;
      if (v.noise) begin req_vaddr = ~v.va; req_root = ~v.root; end
      while (!fin && cyc < 200) begin
         mem_rd_valid = 1'b0;
         if (cd == 0) begin
            mem_rd_valid = 1'b1; mem_rd_data = resp; cd = -1;
         end else if (cd > 0) cd--;
         // R7: busy throughout the walk
         check(busy && !req_ready, {tag, " R7 busy"}, 32'({busy, req_ready}), 32'h2);
         if (mem_rd_en) begin
            reads++;
            if (reads == 1) begin
               check(mem_rd_addr == exp_dir, {tag, " R2 dir addr"}, mem_rd_addr, exp_dir);
               resp = v.pde;
            end else begin
               check(mem_rd_addr == exp_tbl, {tag, " R3 tbl addr"}, mem_rd_addr, exp_tbl);
               resp = v.pte;
            end
            cd = int'(v.lat) - 1;
         end
         if (done || fault) begin
            fin = 1;
            req_valid = 1'b0;
            if (!v.pde[0]) begin
               // R5
               check(fault && !done && !fault_level, {tag, " R5 dir fault"},
                     32'({done, fault, fault_level}), 32'h2);
               check(reads == 1, {tag, " R5 one read"}, 32'(reads), 32'd1);
            end else if (!v.pte[0]) begin
               // R6
               check(fault && !done && fault_level, {tag, " R6 tbl fault"},
                     32'({done, fault, fault_level}), 32'h3);
               check(reads == 2, {tag, " R6 two reads"}, 32'(reads), 32'd2);
            end else begin
               // R4
               check(done && !fault, {tag, " R4 done"}, 32'({done, fault}), 32'h2);
               check(resp_paddr == {v.pte[31:12], v.va[11:0]}, {tag, " R4 paddr"},
                     resp_paddr, {v.pte[31:12], v.va[11:0]});
               check(resp_frame == v.pte[31:12], {tag, " R4 frame"},
                     32'(resp_frame), 32'(v.pte[31:12]));
            end
         end else begin
            cyc++;
            @(negedge clk);
         end
      end
      if (!fin) check(1'b0, {tag, " walk ended"}, 32'(cyc), 32'd0);
      @(negedge clk);
      mem_rd_valid = 1'b0;
      // R9: pulse lasts one cycle, walker ready again
      check_idle({tag, " R9 after end"});
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      vec_t d;
      repeat (3) @(negedge clk);
      // R1
      check_idle("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after release");

      for (int i = 0; i < NV; i++) begin
         walk(VECS[i], $sformatf("vec%0d", i));
      end

      // R4: flag bits in both entries do not alter the result; back-to-back
      d = '{32'h0ABC_DEF0, 32'h0000_2ABC, 32'h0001_1FFF, 32'h0002_2FFF, 3'd4, 1'b1};
      walk(d, "dir R4 flags");

      // R10: reset while the directory read is outstanding
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0040_0000; req_root = 32'h0010_0000;
      @(negedge clk);
      req_valid = 1'b0;
      check(mem_rd_en == 1'b1, "R10 read issued", 32'(mem_rd_en), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_idle("R10 mid-walk reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R10 after release");

      // R2 and R3 again after the reset, with an odd root
      d = '{32'h7FF0_0123, 32'h0ABC_0001, 32'h0DEF_0001, 32'h0123_4001, 3'd2, 1'b0};
      walk(d, "dir R2 R3 post reset");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule